// File: doc/BRIEF.md
# Synchronous SRAM Read Output Path

This block sits between the storage array of a synchronous SRAM and its bidirectional data pins. Each clock edge captures a command: the device is either selected or not, and a selected command is either a read or a write. The array returns data for a captured read during the following cycle. A static mode input decides how that data reaches the pins. In bypass mode it goes straight to the pins in that same cycle. In registered mode it is first captured by an output register on the next rising edge and driven one cycle later.

The deselect path is one register shorter than the read path. When a captured command does not select the device, the drivers shut off in the very next cycle, even if the output register still holds read data. The pins are also released without waiting for a clock whenever the active-low output enable goes high or the sleep input goes high. While sleep is high, the internal capture and output registers freeze, so nothing they hold is lost. The mode input may only be changed while no read is in flight.

Top module: `sram_rd_out_path`

## Requirements
- R1: While `rst_n` is low, `drv_en` is 0 and `dq` is released. This takes effect at once, without a clock, and no read captured before reset is ever driven afterwards.
- R2: With `pipe_mode` = 0, a selected read (`cmd_sel` = 1, `cmd_rd` = 1) captured at an edge makes `drv_en` = 1 for the next cycle, and during that cycle `dq` equals `arr_rdata`. A captured write (`cmd_sel` = 1, `cmd_rd` = 0) or deselect gives no drive in the next cycle.
- R3: With `pipe_mode` = 1, the value on `arr_rdata` in the cycle after a read is captured is registered on the following edge. That value is driven on `dq` during the cycle after that edge, whatever `arr_rdata` does then.
- R4: Reads issued on consecutive cycles give one data beat per cycle. Counting the command cycle as the first, the first beat appears in cycle 2 in bypass mode and in cycle 3 in registered mode.
- R5: A captured deselect (`cmd_sel` = 0) turns the drivers off in the next cycle in both modes, even when the output register holds data from a read captured one edge earlier.
- R6: `oe_n` = 1 makes `drv_en` = 0 immediately, without a clock. Reads still move through the registers meanwhile, so with `oe_n` back at 0 the data of the current stage is driven.
- R7: `sleep` = 1 makes `drv_en` = 0 immediately. While `sleep` is high, commands at the clock edges are not captured and the capture and output registers hold. After `sleep` falls, the data held before sleep is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 1 = registered output, 0 = bypass output; static |
| cmd_sel | input | 1 | Device selected by the command at this edge |
| cmd_rd | input | 1 | Selected command is a read (1) or write (0) |
| arr_rdata | input | DATA_W | Array read data, valid in the cycle after a read is captured |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high low-power hold |
| dq | inout | DATA_W | Tri-state data bus |
| drv_en | output | 1 | High while `dq` is driven |

## Verification
Two pairs of functions can land in one cycle. In registered mode, a deselect can be captured on the same edge that loads read data into the output register. The bench issues a read burst and follows it at once with a deselect. It then expects the last registered beat to be suppressed rather than driven. The asynchronous gates (output enable, sleep and reset) can also change in the middle of a cycle in which a registered beat is being driven. The bench toggles each gate between clock edges and checks `drv_en` a nanosecond later. It also checks that the same beat comes back when output enable or sleep is released.

// File: rtl/sram_rd_out_path.sv
module sram_rd_out_path #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_mode,
  input  logic              cmd_sel,
  input  logic              cmd_rd,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              oe_n,
  input  logic              sleep,
  inout  wire  [DATA_W-1:0] dq,
  output logic              drv_en
);

  logic              cap_sel;
  logic              cap_rd;
  logic              out_rd;
  logic [DATA_W-1:0] out_q;
  logic              rd_live;
  logic [DATA_W-1:0] dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_sel <= 1'b0;
      cap_rd  <= 1'b0;
      out_rd  <= 1'b0;
      out_q   <= '0;
    end else if (!sleep) begin
      cap_sel <= cmd_sel;
      cap_rd  <= cmd_sel & cmd_rd;
      out_rd  <= cap_rd;
      if (cap_rd) out_q <= arr_rdata;
    end
  end

  assign rd_live = pipe_mode ? out_rd : cap_rd;
  assign dout    = pipe_mode ? out_q  : arr_rdata;
  assign drv_en  = rd_live & cap_sel & ~oe_n & ~sleep & rst_n;
  assign dq      = drv_en ? dout : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_rd_out_path_chk.sv
module sram_rd_out_path_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipe_mode,
  input logic              cmd_sel,
  input logic              cmd_rd,
  input logic [DATA_W-1:0] arr_rdata,
  input logic              oe_n,
  input logic              sleep,
  input wire  [DATA_W-1:0] dq,
  input logic              drv_en
);

  always @(negedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (!drv_en); // R1
  end

  AST_FLOW_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && drv_en) |-> (dq == arr_rdata)); // R2

  AST_FLOW_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && drv_en && $past(!sleep)) |-> $past(cmd_sel && cmd_rd)); // R2

  AST_PIPE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && drv_en && $past(!sleep) && $past(!sleep, 2)) |-> $past(cmd_sel && cmd_rd, 2)); // R3

  AST_DESEL_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!sleep) && $past(!cmd_sel)) |-> !drv_en); // R5

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !drv_en); // R6

  AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !drv_en); // R7

endmodule

bind sram_rd_out_path sram_rd_out_path_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_sram_rd_out_path.sv
module test_sram_rd_out_path;
  localparam int W = 8;
  localparam int NV = 33;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pipe_mode = 1'b0;
  logic         cmd_sel = 1'b1;
  logic         cmd_rd = 1'b1;
  logic [W-1:0] arr_rdata = '0;
  logic         oe_n = 1'b0;
  logic         sleep = 1'b0;
  wire  [W-1:0] dq;
  logic         drv_en;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sram_rd_out_path #(.DATA_W(W)) i_sram_rd_out_path (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .cmd_sel(cmd_sel),
    .cmd_rd(cmd_rd), .arr_rdata(arr_rdata), .oe_n(oe_n), .sleep(sleep),
    .dq(dq), .drv_en(drv_en)
  );

  // {pipe, sel, rd, oe_n, sleep}, arr_rdata, expected drv_en, expected dq
  localparam logic [21:0] VEC [0:NV-1] = '{
    {5'b01100, 8'h00, 1'b0, 8'h00},  // 0  R4 flow burst start
    {5'b01100, 8'hA1, 1'b1, 8'hA1},  // 1  R4
    {5'b00000, 8'hA2, 1'b1, 8'hA2},  // 2  R4
    {5'b00000, 8'hA3, 1'b0, 8'h00},  // 3  R2
    {5'b01000, 8'hA4, 1'b0, 8'h00},  // 4  R2 write
    {5'b01100, 8'hA5, 1'b0, 8'h00},  // 5  R2 after write
    {5'b00010, 8'hA6, 1'b0, 8'h00},  // 6  R6
    {5'b10000, 8'h00, 1'b0, 8'h00},  // 7  R5 mode change idle
    {5'b10000, 8'h00, 1'b0, 8'h00},  // 8  R5
    {5'b11100, 8'hB0, 1'b0, 8'h00},  // 9  R3
    {5'b11100, 8'hB1, 1'b0, 8'h00},  // 10 R3
    {5'b11100, 8'hB2, 1'b1, 8'hB1},  // 11 R3 first beat cycle 3
    {5'b10000, 8'hB3, 1'b1, 8'hB2},  // 12 R3
    {5'b10000, 8'hB4, 1'b0, 8'h00},  // 13 R5 deselect kills B3
    {5'b10000, 8'h00, 1'b0, 8'h00},  // 14 R5
    {5'b11100, 8'hC0, 1'b0, 8'h00},  // 15 R3
    {5'b11100, 8'hC1, 1'b0, 8'h00},  // 16 R3
    {5'b11110, 8'hC2, 1'b0, 8'h00},  // 17 R6
    {5'b11100, 8'hC3, 1'b1, 8'hC2},  // 18 R6 pipeline kept moving
    {5'b10000, 8'h00, 1'b1, 8'hC3},  // 19 R5
    {5'b10000, 8'h00, 1'b0, 8'h00},  // 20 R5
    {5'b11100, 8'hE0, 1'b0, 8'h00},  // 21 R3
    {5'b11100, 8'hE1, 1'b0, 8'h00},  // 22 R3
    {5'b11101, 8'hE2, 1'b0, 8'h00},  // 23 R7
    {5'b10001, 8'hE3, 1'b0, 8'h00},  // 24 R7 deselect ignored
    {5'b11100, 8'hE4, 1'b1, 8'hE1},  // 25 R7 held beat
    {5'b10000, 8'hE5, 1'b1, 8'hE4},  // 26 R7
    {5'b10000, 8'h00, 1'b0, 8'h00},  // 27 R7
    {5'b00000, 8'h00, 1'b0, 8'h00},  // 28 R2
    {5'b01100, 8'hF0, 1'b0, 8'h00},  // 29 R2
    {5'b00001, 8'hF1, 1'b0, 8'h00},  // 30 R7
    {5'b00000, 8'hF2, 1'b1, 8'hF2},  // 31 R7 capture held
    {5'b00000, 8'hF3, 1'b0, 8'h00}   // 32 R7
  };

  function automatic string req_of(int i);
    if (i <= 2)  return "R4";
    if (i <= 5)  return "R2";
    if (i == 6)  return "R6";
    if (i <= 8)  return "R5";
    if (i <= 12) return "R3";
    if (i <= 14) return "R5";
    if (i <= 16) return "R3";
    if (i <= 18) return "R6";
    if (i <= 20) return "R5";
    if (i <= 22) return "R3";
    if (i <= 27) return "R7";
    if (i <= 29) return "R2";
    return "R7";
  endfunction

  task automatic check(string req, logic exp_en, logic [W-1:0] exp_dq);
    n_chk++;
    if (drv_en !== exp_en || (exp_en && dq !== exp_dq)) begin
      n_bad++;
      $display("FAIL %s: drv_en=%b dq=%h expected drv_en=%b dq=%h",
               req, drv_en, dq, exp_en, exp_dq);
    end
  endtask

  task automatic step(logic p, logic s, logic r, logic o, logic z, logic [W-1:0] a);
    @(posedge clk);
    #2;
    pipe_mode = p; cmd_sel = s; cmd_rd = r; oe_n = o; sleep = z; arr_rdata = a;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset dominates an active read command
    repeat (3) @(posedge clk);
    #6 check("R1", 1'b0, '0);
    cmd_sel = 1'b0; cmd_rd = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #6 check("R1", 1'b0, '0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      step(v[21], v[20], v[19], v[18], v[17], v[16:9]);
      #14 check(req_of(i), v[8], v[7:0]);
    end

    // asynchronous gating in the middle of a registered beat
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h11);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h22);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h33);
    #6 check("R3", 1'b1, 8'h22);
    oe_n = 1'b1;  #1 check("R6", 1'b0, '0);
    oe_n = 1'b0;  #1 check("R6", 1'b1, 8'h22);
    sleep = 1'b1; #1 check("R7", 1'b0, '0);
    sleep = 1'b0; #1 check("R7", 1'b1, 8'h22);
    rst_n = 1'b0; #1 check("R1", 1'b0, '0);
    cmd_sel = 1'b0; cmd_rd = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #6 check("R1", 1'b0, '0);
    @(posedge clk); #6 check("R1", 1'b0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule